// File: doc/BRIEF.md
# Paged Audio Controller Register File

This block is the host-side register file of a three-channel audio engine. The engine has two playback channels and one record channel. The host reaches it through an 8-bit I/O offset, with byte, halfword or word accesses. Read data is combinational from the registered state. A write takes effect on the clock edge at which the write strobe is sampled.

The block holds the global control word, the serial-control word, a 4-bit page register, a codec word, one 16-bit sample count per channel, and a buffer address and buffer count per channel. The buffer registers sit behind a window at offsets 0x30 to 0x3F. That window is extended by the page register, so the same offsets select different registers depending on the current page. The decoded control words and per-channel values go out to the channel logic.

Each channel reports a finished transfer with a one-cycle pulse. The pulse latches a pending bit when that channel's interrupt enable is set. The OR of the pending bits drives the summary status bit and the interrupt output.

Top module: `aud_regfile`

## Requirements
- R1: After reset the control word reads 0x00000001, status reads 0x00000060, and the page, codec and serial-control words read 0. The interrupt output is low.
- R2: A word write at offset 0x00 replaces the control word. A word write at 0x20 replaces the serial-control word. Both are visible on the next cycle on the word read and on ctrl_o / sctrl_o.
- R3: A byte write at 0x00–0x03 or 0x20–0x23 replaces only the addressed byte lane, taking data bits 7:0.
- R4: A halfword write at 0x00 replaces control bits 15:0, and one at 0x02 replaces bits 31:16, taking data bits 15:0.
- R5: A byte or word write at 0x0C stores only data bits 3:0 in the page register. A byte or word read at 0x0C returns the page zero-extended.
- R6: Offsets 0x30–0x3F are prefixed with the page (effective address = page·256 + offset). The word registers are:
  - 0xC30 / 0xC34: playback-1 buffer address / count
  - 0xC38 / 0xC3C: playback-2 buffer address / count
  - 0xD30 / 0xD34: record buffer address / count
  - Any other paged slot is unmapped.
- R7: A halfword or word write at 0x24, 0x28 or 0x2C stores data bits 15:0 as the playback-1, playback-2 or record sample count. A word read there returns the count zero-extended. A halfword read at 0x26, 0x2A or 0x2E returns 0.
- R8: A halfword write at 0x10 stores 16 bits in the codec word, and a word read at 0x10 returns it zero-extended. Word writes at 0x10 are ignored.
- R9: Pulse bits map as follows: done_i[2] is playback 1, done_i[1] is playback 2, done_i[0] is record. A pulse sets status bit 2, 1 or 0 respectively, but only if the matching serial-control enable is set: bit 8, 9 or 10.
- R10: Status bit 31 and irq_o equal the OR of status bits 2:0. Status bits 6:5 read as 1, and all other status bits read as 0.
- R11: A write that changes an enable bit from 1 to 0 clears that channel's pending bit. A write that leaves an already-clear enable at 0 does not. If a pulse sets a pending bit in the same cycle that a write would clear it, the pending bit ends up set.
- R12: A byte read at 0x1B returns 5. Any other unmapped read returns 0xFFFFFFFF. Writes to unmapped offsets change no state.
- R13: A byte read at 0x00–0x03 or 0x04–0x07 returns the addressed byte of control or status, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| addr_i | input | 8 | I/O byte offset |
| wdata_i | input | 32 | Write data, right-aligned for narrow writes |
| rdata_o | output | 32 | Read data, zero-extended for narrow reads |
| done_i | input | 3 | Transfer-complete pulses (2 play1, 1 play2, 0 record) |
| irq_o | output | 1 | Interrupt request |
| ctrl_o | output | 32 | Control word |
| sctrl_o | output | 32 | Serial-control word |
| scount_o | output | 48 | Sample counts, 16 bits per channel, play1 lowest |
| frame_addr_o | output | 96 | Buffer addresses, 32 bits per channel, play1 lowest |
| frame_cnt_o | output | 96 | Buffer counts, 32 bits per channel, play1 lowest |

## Verification
Narrow writes are tried on every lane and on both halves with distinct data, so that a lane or half swap shows up as a wrong byte in the read-back. The paged window is read under page 0, page 0xC and page 0xD. This separates the paged slots from each other and from the unpaged view, and shows that the unused page-D slot is unmapped. Completion pulses are sent once with all enables clear and once with all enables set, and then combined with enable-clearing writes:
- an enable that falls clears its pending bit;
- an enable that was already clear does not;
- a pulse that coincides with a falling enable wins.

A behavioural model tracks every output on each clock.

// File: rtl/aud_regs_pkg.sv
package aud_regs_pkg;
  localparam int NCH = 3;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int PW = 4;
  localparam int EAW = AW + PW;
  localparam int SCW = 16;
  localparam int IEN_LSB = 8;

  localparam logic [EAW-1:0] OFF_CTRL   = 12'h000;
  localparam logic [EAW-1:0] OFF_STAT   = 12'h004;
  localparam logic [EAW-1:0] OFF_PAGE   = 12'h00C;
  localparam logic [EAW-1:0] OFF_CODEC  = 12'h010;
  localparam logic [EAW-1:0] OFF_LEGACY = 12'h01B;
  localparam logic [EAW-1:0] OFF_SCTRL  = 12'h020;
  localparam logic [EAW-1:0] OFF_SC0    = 12'h024;
  localparam logic [AW-1:0]  WIN_TAG    = 8'h30;

  localparam logic [DW-1:0] CTRL_RST   = 32'h0000_0001;
  localparam logic [7:0]    STAT_FIXED = 8'h60;
  localparam logic [DW-1:0] LEGACY_VAL = 32'd5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  function automatic logic [EAW-1:0] sc_off(int c);
    return OFF_SC0 + EAW'(4 * c);
  endfunction

  // last channel is record, it lives on the next page
  function automatic logic [EAW-1:0] frame_base(int c);
    return (c == NCH - 1) ? 12'hD30 : 12'hC30 + EAW'(8 * c);
  endfunction
endpackage

// File: rtl/aud_addr_map.sv
module aud_addr_map
  import aud_regs_pkg::*;
(
  input  logic [AW-1:0]  addr_i,
  input  logic [PW-1:0]  page_i,
  output logic [EAW-1:0] eaddr_o
);
  logic in_win;
  assign in_win  = (addr_i[AW-1:4] == WIN_TAG[AW-1:4]);
  assign eaddr_o = in_win ? {page_i, addr_i} : {{PW{1'b0}}, addr_i};
endmodule

// File: rtl/aud_lane_merge.sv
module aud_lane_merge
  import aud_regs_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] wdata_i,
  input  acc_size_e    size_i,
  input  logic [1:0]   lane_i,
  output logic [W-1:0] merged_o
);
  localparam int NB = W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam logic [1:0] LB = 2'(b);
    logic       sel;
    logic [7:0] src;
    always_comb begin
      unique case (size_i)
        SZ_BYTE: begin sel = (lane_i == LB);       src = wdata_i[7:0]; end
        SZ_HALF: begin sel = (lane_i[1] == LB[1]); src = wdata_i[(b % 2) * 8 +: 8]; end
        SZ_WORD: begin sel = 1'b1;                 src = wdata_i[b * 8 +: 8]; end
        default: begin sel = 1'b0;                 src = 8'h00; end
      endcase
    end
    assign merged_o[b * 8 +: 8] = sel ? src : old_i[b * 8 +: 8];
  end
endmodule

// File: rtl/aud_irq_ctrl.sv
module aud_irq_ctrl #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] ien_i,
  input  logic [N-1:0] ien_fall_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q;

  // set term is ORed last so a coincident pulse wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~ien_fall_i) | (done_i & ien_i);
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;
endmodule

// File: rtl/aud_regfile.sv
module aud_regfile
  import aud_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        size_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [2:0]        done_i,
  output logic              irq_o,
  output logic [31:0]       ctrl_o,
  output logic [31:0]       sctrl_o,
  output logic [47:0]       scount_o,
  output logic [95:0]       frame_addr_o,
  output logic [95:0]       frame_cnt_o
);
  acc_size_e sz;
  logic [EAW-1:0] eaddr, base;
  logic [1:0] lane;
  logic is_b, is_h, is_w;

  logic [DW-1:0]  ctrl_q, sctrl_q, codec_q, ctrl_mrg, sctrl_mrg, stat_w;
  logic [PW-1:0]  page_q;
  logic [SCW-1:0] sc_q [NCH];
  logic [DW-1:0]  fa_q [NCH];
  logic [DW-1:0]  fc_q [NCH];
  logic ctrl_we, sctrl_we, page_we, codec_we;
  logic [NCH-1:0] sc_we, fa_we, fc_we;
  logic [NCH-1:0] ien, ien_new, ien_fall, pend_w;

  assign sz   = acc_size_e'(size_i);
  assign is_b = (sz == SZ_BYTE);
  assign is_h = (sz == SZ_HALF);
  assign is_w = (sz == SZ_WORD);
  assign lane = addr_i[1:0];

  aud_addr_map u_map (
    .addr_i  (addr_i),
    .page_i  (page_q),
    .eaddr_o (eaddr)
  );
  assign base = {eaddr[EAW-1:2], 2'b00};

  aud_lane_merge #(.W(DW)) u_ctrl_mrg (
    .old_i    (ctrl_q),
    .wdata_i  (wdata_i),
    .size_i   (sz),
    .lane_i   (lane),
    .merged_o (ctrl_mrg)
  );

  aud_lane_merge #(.W(DW)) u_sctrl_mrg (
    .old_i    (sctrl_q),
    .wdata_i  (wdata_i),
    .size_i   (sz),
    .lane_i   (lane),
    .merged_o (sctrl_mrg)
  );

  assign ctrl_we  = wr_en_i && (base == OFF_CTRL) &&
                    (is_b || (is_h && !lane[0]) || (is_w && lane == 2'b00));
  assign sctrl_we = wr_en_i && (base == OFF_SCTRL) &&
                    (is_b || (is_w && lane == 2'b00));
  assign page_we  = wr_en_i && (eaddr == OFF_PAGE) && (is_b || is_w);
  assign codec_we = wr_en_i && (eaddr == OFF_CODEC) && is_h;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign sc_we[c] = wr_en_i && (is_h || is_w) && (eaddr == sc_off(c));
    assign fa_we[c] = wr_en_i && is_w && (eaddr == frame_base(c));
    assign fc_we[c] = wr_en_i && is_w && (eaddr == frame_base(c) + EAW'(4));
    assign scount_o[c * SCW +: SCW]   = sc_q[c];
    assign frame_addr_o[c * DW +: DW] = fa_q[c];
    assign frame_cnt_o[c * DW +: DW]  = fc_q[c];
  end

  // status bit k pairs with enable bit IEN_LSB + (NCH-1-k)
  for (genvar k = 0; k < NCH; k++) begin : g_ien
    assign ien[k]     = sctrl_q[IEN_LSB + NCH - 1 - k];
    assign ien_new[k] = sctrl_mrg[IEN_LSB + NCH - 1 - k];
  end
  assign ien_fall = sctrl_we ? (ien & ~ien_new) : '0;

  aud_irq_ctrl #(.N(NCH)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done_i),
    .ien_i      (ien),
    .ien_fall_i (ien_fall),
    .pend_o     (pend_w),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      sctrl_q <= '0;
      page_q  <= '0;
      codec_q <= '0;
    end else begin
      if (ctrl_we)  ctrl_q  <= ctrl_mrg;
      if (sctrl_we) sctrl_q <= sctrl_mrg;
      if (page_we)  page_q  <= wdata_i[PW-1:0];
      if (codec_we) codec_q <= {{(DW-SCW){1'b0}}, wdata_i[SCW-1:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        sc_q[c] <= '0;
        fa_q[c] <= '0;
        fc_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (sc_we[c]) sc_q[c] <= wdata_i[SCW-1:0];
        if (fa_we[c]) fa_q[c] <= wdata_i;
        if (fc_we[c]) fc_q[c] <= wdata_i;
      end
    end
  end

  assign stat_w = {|pend_w, {(DW-9){1'b0}}, STAT_FIXED | {{(8-NCH){1'b0}}, pend_w}};

  always_comb begin
    rdata_o = '1;
    unique case (sz)
      SZ_BYTE: begin
        if (eaddr == OFF_LEGACY)    rdata_o = LEGACY_VAL;
        else if (eaddr == OFF_PAGE) rdata_o = {{(DW-PW){1'b0}}, page_q};
        else if (base == OFF_CTRL)  rdata_o = {24'h0, ctrl_q[{lane, 3'b000} +: 8]};
        else if (base == OFF_STAT)  rdata_o = {24'h0, stat_w[{lane, 3'b000} +: 8]};
      end
      SZ_HALF: begin
        for (int c = 0; c < NCH; c++)
          if (eaddr == sc_off(c) + EAW'(2)) rdata_o = '0;
      end
      SZ_WORD: begin
        if (lane == 2'b00) begin
          if (eaddr == OFF_CTRL)  rdata_o = ctrl_q;
          if (eaddr == OFF_STAT)  rdata_o = stat_w;
          if (eaddr == OFF_PAGE)  rdata_o = {{(DW-PW){1'b0}}, page_q};
          if (eaddr == OFF_CODEC) rdata_o = codec_q;
          if (eaddr == OFF_SCTRL) rdata_o = sctrl_q;
          for (int c = 0; c < NCH; c++) begin
            if (eaddr == sc_off(c))                rdata_o = {{(DW-SCW){1'b0}}, sc_q[c]};
            if (eaddr == frame_base(c))            rdata_o = fa_q[c];
            if (eaddr == frame_base(c) + EAW'(4))  rdata_o = fc_q[c];
          end
        end
      end
      default: rdata_o = '1;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign sctrl_o = sctrl_q;
endmodule

// File: rtl/aud_regfile_chk.sv
module aud_regfile_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [2:0]  done_i,
  input logic [31:0] ctrl_o,
  input logic [31:0] sctrl_o,
  input logic [2:0]  pend_i
);
  // R9: enabled pulse latches pending bit
  p_pulse_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i[2] && sctrl_o[8]) |=> pend_i[2]);

  // R9: pending bit never rises without a pulse
  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_i[0] && !done_i[0]) |=> !pend_i[0]);

  // R11: falling enable without coincident pulse leaves bit clear
  p_fall_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sctrl_o[8]) && !$past(done_i[2])) |-> !pend_i[2]);

  // R2: register state only moves on a write
  p_hold_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(ctrl_o) && $stable(sctrl_o)));
endmodule

bind aud_regfile aud_regfile_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .done_i  (done_i),
  .ctrl_o  (ctrl_o),
  .sctrl_o (sctrl_o),
  .pend_i  (pend_w)
);

// File: tb/aud_regfile_bench.sv
module aud_regfile_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  size_i = 2'd2;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = 32'h0;
  logic [2:0]  done_i = 3'b000;
  logic [31:0] rdata_o, ctrl_o, sctrl_o;
  logic        irq_o;
  logic [47:0] scount_o;
  logic [95:0] frame_addr_o, frame_cnt_o;

  aud_regfile u_aud_regfile (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .size_i(size_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .done_i(done_i),
    .irq_o(irq_o), .ctrl_o(ctrl_o), .sctrl_o(sctrl_o), .scount_o(scount_o),
    .frame_addr_o(frame_addr_o), .frame_cnt_o(frame_cnt_o)
  );

  always #5ns clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit run_cmp = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [31:0] m_ctrl = 32'h1, m_sctrl = 32'h0;
  logic [3:0]  m_page = 4'h0;
  logic [15:0] m_codec = 16'h0;
  logic [2:0]  m_pend = 3'b000;
  logic [15:0] m_sc [3] = '{default: 16'h0};
  logic [31:0] m_fa [3] = '{default: 32'h0};
  logic [31:0] m_fc [3] = '{default: 32'h0};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] eff(logic [7:0] a);
    return (a >= 8'h30 && a <= 8'h3F) ? {m_page, a} : {4'h0, a};
  endfunction

  task automatic m_apply(bit wr, logic [1:0] sz, logic [7:0] a, logic [31:0] d, logic [2:0] dn);
    logic [11:0] e;
    logic [31:0] nsct;
    logic [2:0] ien_old, ien_new;
    logic [11:0] fb;
    e = eff(a);
    nsct = m_sctrl;
    ien_old = {m_sctrl[8], m_sctrl[9], m_sctrl[10]};
    if (wr) begin
      if (e[11:2] == 10'h0) begin
        if (sz == 2'd0) m_ctrl[e[1:0]*8 +: 8] = d[7:0];
        else if (sz == 2'd1 && !e[0]) m_ctrl[e[1]*16 +: 16] = d[15:0];
        else if (sz == 2'd2 && e[1:0] == 2'b00) m_ctrl = d;
      end
      if (e[11:2] == 10'h8) begin
        if (sz == 2'd0) nsct[e[1:0]*8 +: 8] = d[7:0];
        else if (sz == 2'd2 && e[1:0] == 2'b00) nsct = d;
      end
      if (e == 12'h00C && sz != 2'd1) m_page = d[3:0];
      if (e == 12'h010 && sz == 2'd1) m_codec = d[15:0];
      for (int c = 0; c < 3; c++) begin
        fb = (c == 2) ? 12'hD30 : 12'hC30 + 12'(8 * c);
        if (e == 12'h024 + 12'(4 * c) && sz != 2'd0) m_sc[c] = d[15:0];
        if (sz == 2'd2 && e == fb) m_fa[c] = d;
        if (sz == 2'd2 && e == fb + 12'd4) m_fc[c] = d;
      end
    end
    ien_new = {nsct[8], nsct[9], nsct[10]};
    m_pend = (m_pend & ~(ien_old & ~ien_new)) | (dn & ien_old);
    m_sctrl = nsct;
  endtask

  task automatic cyc(bit wr, logic [1:0] sz, logic [7:0] a, logic [31:0] d, logic [2:0] dn);
    @(negedge clk_i);
    wr_en_i = wr; size_i = sz; addr_i = a; wdata_i = d; done_i = dn;
    @(posedge clk_i);
    #1ns;
    m_apply(wr, sz, a, d, dn);
    wr_en_i = 1'b0; done_i = 3'b000;
  endtask

  task automatic wr(logic [1:0] sz, logic [7:0] a, logic [31:0] d);
    cyc(1'b1, sz, a, d, 3'b000);
  endtask

  task automatic pulse(logic [2:0] dn);
    cyc(1'b0, 2'd2, 8'h00, 32'h0, dn);
  endtask

  task automatic rd(logic [1:0] sz, logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i);
    wr_en_i = 1'b0; size_i = sz; addr_i = a;
    #1ns;
    chk(tag, rdata_o, exp);
  endtask

  // per-clock comparison of all registered outputs against the model
  always @(negedge clk_i) begin
    if (run_cmp) begin
      chk("R2 ctrl_o", ctrl_o, m_ctrl);
      chk("R3 sctrl_o", sctrl_o, m_sctrl);
      chk("R10 irq_o", {31'b0, irq_o}, {31'b0, |m_pend});
      for (int c = 0; c < 3; c++) begin
        chk("R7 scount_o", {16'b0, scount_o[c*16 +: 16]}, {16'b0, m_sc[c]});
        chk("R6 frame_addr_o", frame_addr_o[c*32 +: 32], m_fa[c]);
        chk("R6 frame_cnt_o", frame_cnt_o[c*32 +: 32], m_fc[c]);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2ms;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    run_cmp = 1'b1;

    // R1 reset state
    rd(2'd2, 8'h00, 32'h0000_0001, "R1 ctrl");
    rd(2'd2, 8'h04, 32'h0000_0060, "R1 status");
    rd(2'd2, 8'h0C, 32'h0, "R1 page");
    rd(2'd2, 8'h10, 32'h0, "R1 codec");
    rd(2'd2, 8'h20, 32'h0, "R1 sctrl");
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R2 word writes
    wr(2'd2, 8'h00, 32'h1234_5678);
    rd(2'd2, 8'h00, 32'h1234_5678, "R2 ctrl word");

    // R3 byte lanes
    wr(2'd0, 8'h02, 32'hFFFF_FFAB);
    rd(2'd2, 8'h00, 32'h12AB_5678, "R3 ctrl lane2");
    wr(2'd0, 8'h00, 32'h0000_00C3);
    rd(2'd2, 8'h00, 32'h12AB_56C3, "R3 ctrl lane0");
    wr(2'd0, 8'h21, 32'h0000_0030);
    rd(2'd2, 8'h20, 32'h0000_3000, "R3 sctrl lane1");

    // R4 halfword halves
    wr(2'd1, 8'h02, 32'hAAAA_BEEF);
    rd(2'd2, 8'h00, 32'hBEEF_56C3, "R4 ctrl upper half");
    wr(2'd1, 8'h00, 32'h0000_1111);
    rd(2'd2, 8'h00, 32'hBEEF_1111, "R4 ctrl lower half");

    // R13 byte reads
    rd(2'd0, 8'h03, 32'h0000_00BE, "R13 ctrl byte3");
    rd(2'd0, 8'h04, 32'h0000_0060, "R13 status byte0");
    rd(2'd0, 8'h07, 32'h0000_0000, "R13 status byte3");

    // R5 page
    wr(2'd2, 8'h0C, 32'hFFFF_FFFD);
    rd(2'd2, 8'h0C, 32'h0000_000D, "R5 page word");
    rd(2'd0, 8'h0C, 32'h0000_000D, "R5 page byte");

    // R6 paged window
    wr(2'd2, 8'h30, 32'hB000_0000);
    wr(2'd2, 8'h34, 32'hB111_1111);
    wr(2'd2, 8'h38, 32'h9999_9999);
    wr(2'd0, 8'h0C, 32'h0000_00FC);
    rd(2'd2, 8'h0C, 32'h0000_000C, "R5 page byte write");
    wr(2'd2, 8'h30, 32'hA000_0000);
    wr(2'd2, 8'h34, 32'hA111_1111);
    wr(2'd2, 8'h38, 32'hA222_2222);
    wr(2'd2, 8'h3C, 32'hA333_3333);
    rd(2'd2, 8'h30, 32'hA000_0000, "R6 play1 addr");
    rd(2'd2, 8'h3C, 32'hA333_3333, "R6 play2 count");
    wr(2'd2, 8'h0C, 32'h0000_000D);
    rd(2'd2, 8'h30, 32'hB000_0000, "R6 record addr");
    rd(2'd2, 8'h34, 32'hB111_1111, "R6 record count");
    rd(2'd2, 8'h38, 32'hFFFF_FFFF, "R6 unmapped page D slot");
    wr(2'd2, 8'h0C, 32'h0000_0000);
    rd(2'd2, 8'h30, 32'hFFFF_FFFF, "R6 page 0 window");

    // R7 sample counts
    wr(2'd2, 8'h24, 32'hDEAD_1234);
    wr(2'd1, 8'h28, 32'h0000_5555);
    wr(2'd1, 8'h2C, 32'h0000_7777);
    rd(2'd2, 8'h24, 32'h0000_1234, "R7 play1 count");
    rd(2'd2, 8'h28, 32'h0000_5555, "R7 play2 count");
    rd(2'd2, 8'h2C, 32'h0000_7777, "R7 record count");
    rd(2'd1, 8'h26, 32'h0000_0000, "R7 half upper");

    // R8 codec
    wr(2'd1, 8'h10, 32'hFFFF_CAFE);
    wr(2'd2, 8'h10, 32'h0101_0101);
    rd(2'd2, 8'h10, 32'h0000_CAFE, "R8 codec");

    // R9 pulses gated by enable
    pulse(3'b111);
    rd(2'd2, 8'h04, 32'h0000_0060, "R9 disabled pulses");
    wr(2'd2, 8'h20, 32'h0000_0700);
    pulse(3'b111);
    rd(2'd2, 8'h04, 32'h8000_0067, "R9 R10 all pending");
    chk("R10 irq high", {31'b0, irq_o}, 32'h1);

    // R11 clearing rules
    wr(2'd0, 8'h21, 32'h0000_0006);
    rd(2'd2, 8'h04, 32'h8000_0063, "R11 play1 cleared");
    cyc(1'b1, 2'd0, 8'h21, 32'h0000_0004, 3'b010);
    rd(2'd2, 8'h04, 32'h8000_0063, "R11 set wins");
    wr(2'd0, 8'h21, 32'h0000_0000);
    rd(2'd2, 8'h04, 32'h8000_0062, "R11 already-clear enable");
    wr(2'd0, 8'h21, 32'h0000_0002);
    wr(2'd0, 8'h21, 32'h0000_0000);
    rd(2'd2, 8'h04, 32'h0000_0060, "R10 all clear");
    chk("R10 irq low", {31'b0, irq_o}, 32'h0);

    // R12 unmapped
    rd(2'd0, 8'h1B, 32'h0000_0005, "R12 legacy byte");
    wr(2'd2, 8'h14, 32'h1234_5678);
    rd(2'd2, 8'h14, 32'hFFFF_FFFF, "R12 unmapped word");
    rd(2'd2, 8'h08, 32'hFFFF_FFFF, "R12 unmapped 0x08");
    rd(2'd1, 8'h00, 32'hFFFF_FFFF, "R12 half read ctrl");
    rd(2'd2, 8'h00, 32'hBEEF_1111, "R12 ctrl untouched");

    @(negedge clk_i);
    run_cmp = 1'b0;
    summary();
  end
endmodule